// File: doc/BRIEF.md
# Two-Channel Edge Capture Timer

This block is a 16-bit free-running counter with two input channels, set up and read over a small 8-bit register bus. A 3-bit rate field picks what advances the counter. Codes 0 to 6 step it once every 2^code bus clock cycles. Code 7 steps it once for each rising edge of an external clock pin.

Each channel watches its own input pin. When the transition chosen by its edge-select field occurs, the channel stores the counter in a 16-bit capture register and sets its status flag. The capture register is read as two bytes. Software can poll the flag, or it can enable the channel interrupt, which is asserted while the flag is set. Writing a 0 to the flag clears it.

Top module: `cap_timer`

## Requirements
- R1: The counter is 16 bits, resets to 0 and wraps. It advances once every 2^c clock cycles for rate code c in 0..6, where c is bits 2:0 of the control register at address 0. With code 7 it advances once for each rising edge of `ext_clk`, counted after a two-flop synchronizer.
- R2: Read addresses: 0 = control, 1 = counter high byte, 2 = counter low byte. Channel n (n = 0, 1) uses base 4+4n: +0 status/control, +1 capture high byte (bits 15:8), +2 capture low byte (bits 7:0). Any other address reads 0.
- R3: Channel pins pass through two synchronizing flops and then an edge detector. The capture edge takes the counter value that was present before that edge. Edge select is status/control bits 3:2: 01 = rising only, 10 = falling only, 11 = both. A transition of the other polarity is ignored.
- R4: With edge select 00, no transition on a pin changes that channel's flag or capture register.
- R5: Every qualifying transition overwrites the capture register, even when the flag is already set.
- R6: Flag = status/control bit 7. A capture sets it. A bus write with bit 7 = 0 clears it. A bus write with bit 7 = 1 leaves it unchanged. A capture in the same cycle as a clearing write leaves it set.
- R7: `irq[n]` is 1 exactly when channel n's flag and its interrupt enable (bit 6) are both 1.
- R8: Status/control layout: bit 7 flag, bit 6 interrupt enable, bits 5:4 mode, bits 3:2 edge select, bit 1 overflow-toggle, bit 0 max-duty. Bits 6:0 are stored as written and have no further effect, except that channel 1 bit 5 always reads 0. The control register and both status/control registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| ext_clk | input | 1 | External counter clock pin |
| cap_pin | input | 2 | Channel input pins |
| irq | output | 2 | Per-channel interrupt request |

## Verification
A channel's flag can receive a set from a capture and a clear from a bus write on the same edge. The bench sets the flag first. It then drives a pin transition and times a clearing write so that it lands on the third rising clock edge after the pin change, the edge on which the capture completes. The result is judged by reading the flag back as 1 and the capture register as the frozen counter value. The counter is frozen by selecting the external clock with the pin held low, so that the expected capture value is exact.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int PS_W    = 3;
    localparam int ADDR_W  = 4;
    localparam int NUM_CH  = 2;
    localparam int DIV_W   = (1 << PS_W) - 2;

    localparam logic [PS_W-1:0] PS_EXT = '1;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd2;
    localparam int CH_BASE   = 4;
    localparam int CH_STRIDE = 4;
    localparam int OFF_SC = 0;
    localparam int OFF_HI = 1;
    localparam int OFF_LO = 2;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic      flag;
        logic      ie;
        logic [1:0] mode;
        edge_sel_e els;
        logic      tov;
        logic      maxd;
    } ch_ctrl_t;

    function automatic logic [ADDR_W-1:0] ch_addr(input int ch, input int off);
        return ADDR_W'(CH_BASE + ch * CH_STRIDE + off);
    endfunction

    function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
        case (sel)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_ANY:  return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] rate_mask(input logic [PS_W-1:0] code);
        logic [DIV_W:0] full;
        full = (DIV_W+1)'(1) << code;
        return DIV_W'(full - 1'b1);
    endfunction
endpackage

// File: rtl/cap_counter.sv
module cap_counter
    import cap_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PS_W-1:0] rate_sel,
    input  logic            ext_clk,
    output logic [W-1:0]    count
);
    logic [DIV_W-1:0] div_q;
    logic ext_s1, ext_s2, ext_prev;
    logic tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q    <= '0;
            ext_s1   <= 1'b0;
            ext_s2   <= 1'b0;
            ext_prev <= 1'b0;
        end else begin
            div_q    <= div_q + 1'b1;
            ext_s1   <= ext_clk;
            ext_s2   <= ext_s1;
            ext_prev <= ext_s2;
        end
    end

    always_comb begin
        if (rate_sel == PS_EXT)
            tick = ext_s2 & ~ext_prev;
        else
            tick = (div_q & rate_mask(rate_sel)) == rate_mask(rate_sel);
    end

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (tick)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/cap_channel.sv
module cap_channel
    import cap_pkg::*;
#(
    parameter int W = CNT_W,
    parameter bit MODE_HI_EN = 1'b1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  logic [W-1:0] count,
    input  logic     sc_wr,
    input  ch_ctrl_t sc_wdata,
    output ch_ctrl_t sc,
    output logic [W-1:0] cap_val,
    output logic     fire,
    output logic     irq
);
    logic pin_s1, pin_s2, pin_prev;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_s1   <= 1'b0;
            pin_s2   <= 1'b0;
            pin_prev <= 1'b0;
        end else begin
            pin_s1   <= pin;
            pin_s2   <= pin_s1;
            pin_prev <= pin_s2;
        end
    end

    assign rise = pin_s2 & ~pin_prev;
    assign fall = ~pin_s2 & pin_prev;
    assign fire = edge_hit(sc.els, rise, fall);

    always_ff @(posedge clk) begin
        if (rst) begin
            sc <= '0;
        end else begin
            if (sc_wr) begin
                sc.ie   <= sc_wdata.ie;
                sc.mode <= {sc_wdata.mode[1] & MODE_HI_EN, sc_wdata.mode[0]};
                sc.els  <= sc_wdata.els;
                sc.tov  <= sc_wdata.tov;
                sc.maxd <= sc_wdata.maxd;
            end
            if (fire)
                sc.flag <= 1'b1;
            else if (sc_wr && !sc_wdata.flag)
                sc.flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fire)
            cap_val <= count;
    end

    assign irq = sc.flag & sc.ie;
endmodule

// File: rtl/cap_timer.sv
module cap_timer
    import cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        ext_clk,
    input  logic [1:0]  cap_pin,
    output logic [1:0]  irq
);
    logic [PS_W-1:0] rate_q;
    logic [CNT_W-1:0] count;

    ch_ctrl_t sc_arr [NUM_CH];
    logic [NUM_CH-1:0][CNT_W-1:0] cap_arr;
    logic [NUM_CH-1:0][1:0] els_arr;
    logic [NUM_CH-1:0] fire_arr, flag_arr, ie_arr;

    always_ff @(posedge clk) begin
        if (rst)
            rate_q <= '0;
        else if (bus_wr && bus_addr == A_CTRL)
            rate_q <= bus_wdata[PS_W-1:0];
    end

    cap_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .rate_sel(rate_q), .ext_clk(ext_clk), .count(count)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sc_wr;
        assign sc_wr = bus_wr && (bus_addr == ch_addr(i, OFF_SC));
        cap_channel #(.W(CNT_W), .MODE_HI_EN(i == 0)) u_ch (
            .clk(clk), .rst(rst), .pin(cap_pin[i]), .count(count),
            .sc_wr(sc_wr), .sc_wdata(ch_ctrl_t'(bus_wdata)),
            .sc(sc_arr[i]), .cap_val(cap_arr[i]), .fire(fire_arr[i]), .irq(irq[i])
        );
        assign els_arr[i]  = sc_arr[i].els;
        assign flag_arr[i] = sc_arr[i].flag;
        assign ie_arr[i]   = sc_arr[i].ie;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)   bus_rdata = BYTE_W'(rate_q);
        if (bus_addr == A_CNT_HI) bus_rdata = count[2*BYTE_W-1:BYTE_W];
        if (bus_addr == A_CNT_LO) bus_rdata = count[BYTE_W-1:0];
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ch_addr(i, OFF_SC)) bus_rdata = sc_arr[i];
            if (bus_addr == ch_addr(i, OFF_HI)) bus_rdata = cap_arr[i][2*BYTE_W-1:BYTE_W];
            if (bus_addr == ch_addr(i, OFF_LO)) bus_rdata = cap_arr[i][BYTE_W-1:0];
        end
    end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk
    import cap_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic [CNT_W-1:0] count,
    input logic [NUM_CH-1:0][CNT_W-1:0] cap_arr,
    input logic [NUM_CH-1:0][1:0] els_arr,
    input logic [NUM_CH-1:0] fire_arr,
    input logic [NUM_CH-1:0] flag_arr,
    input logic [NUM_CH-1:0] ie_arr,
    input logic [1:0] irq
);
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (count != $past(count)) |-> (count == $past(count) + 1'b1));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R3
        cap_value_chk: assert property (@(posedge clk) disable iff (rst)
            fire_arr[i] |=> (cap_arr[i] == $past(count)));
        // R4
        off_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
            (els_arr[i] == 2'b00) |-> !fire_arr[i]);
        // R5
        recap_flag_chk: assert property (@(posedge clk) disable iff (rst)
            fire_arr[i] |=> flag_arr[i]);
        // R6
        flag_source_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(flag_arr[i]) |-> $past(fire_arr[i]));
        // R7
        irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
            irq[i] |-> (flag_arr[i] && ie_arr[i]));
    end
endmodule

bind cap_timer cap_timer_chk u_chk (
    .clk(clk), .rst(rst), .count(count), .cap_arr(cap_arr), .els_arr(els_arr),
    .fire_arr(fire_arr), .flag_arr(flag_arr), .ie_arr(ie_arr), .irq(irq)
);

// File: tb/cap_timer_test.sv
module cap_timer_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic ext_clk = 1'b0;
    logic [1:0] cap_pin = '0;
    logic [1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cap_timer uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .cap_pin(cap_pin), .irq(irq)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd16(input logic [3:0] a_hi, output logic [15:0] v);
        logic [7:0] h, l;
        rd(a_hi, h);
        rd(a_hi + 4'd1, l);
        v = {h, l};
    endtask

    task automatic pulse_ext(input int n);
        for (int k = 0; k < n; k++) begin
            ext_clk = 1'b1; repeat (2) @(negedge clk);
            ext_clk = 1'b0; repeat (2) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic set_pin(input int ch, input logic v);
        @(negedge clk);
        cap_pin[ch] = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        rd(4'd0, d); check("R8 ctrl reset", d, 0);
        rd(4'd4, d); check("R8 sc0 reset", d, 0);
        rd(4'd8, d); check("R8 sc1 reset", d, 0);
        check("R7 irq reset", irq, 0);
    endtask

    task automatic t_prescale;
        logic [7:0] a, b;
        int codes [3] = '{0, 3, 6};
        foreach (codes[j]) begin
            wr(4'd0, 8'(codes[j]));
            repeat (4) @(negedge clk);
            rd(4'd2, a);
            repeat (63) @(negedge clk);
            rd(4'd2, b);
            check($sformatf("R1 rate code %0d", codes[j]), 8'(b - a), 64 >> codes[j]);
        end
    endtask

    task automatic t_ext;
        logic [15:0] v0, v1;
        wr(4'd0, 8'd7);
        repeat (4) @(negedge clk);
        rd16(4'd1, v0);
        repeat (10) @(negedge clk);
        rd16(4'd1, v1);
        check("R1 ext idle holds", v1, v0);
        pulse_ext(5);
        rd16(4'd1, v1);
        check("R1 ext five edges", v1, 16'(v0 + 5));
    endtask

    task automatic t_rise;
        logic [15:0] v, c;
        logic [7:0] d;
        wr(4'd4, 8'h04);
        pulse_ext(3);
        rd16(4'd1, v);
        set_pin(0, 1'b1);
        rd16(4'd5, c); check("R3 R2 rising capture value", c, v);
        rd(4'd4, d);   check("R6 flag set on capture", d, 8'h84);
        pulse_ext(2);
        set_pin(0, 1'b0);
        rd16(4'd5, c); check("R3 falling ignored in rise mode", c, v);
    endtask

    task automatic t_fall;
        logic [15:0] v, c;
        logic [7:0] d;
        wr(4'd4, 8'h08);
        rd(4'd4, d); check("R6 write 0 clears flag", d, 8'h08);
        set_pin(0, 1'b1);
        rd(4'd4, d); check("R3 rising ignored in fall mode", d, 8'h08);
        pulse_ext(1);
        rd16(4'd1, v);
        set_pin(0, 1'b0);
        rd16(4'd5, c); check("R3 falling capture value", c, v);
        rd(4'd4, d);   check("R3 falling sets flag", d, 8'h88);
    endtask

    task automatic t_write1;
        logic [7:0] d;
        wr(4'd4, 8'h08);
        wr(4'd4, 8'h88);
        rd(4'd4, d); check("R6 write 1 no effect", d, 8'h08);
    endtask

    task automatic t_off;
        logic [15:0] c0, c1;
        logic [7:0] d;
        wr(4'd4, 8'h00);
        rd16(4'd5, c0);
        pulse_ext(1);
        set_pin(0, 1'b1);
        set_pin(0, 1'b0);
        rd(4'd4, d);   check("R4 disabled no flag", d, 8'h00);
        rd16(4'd5, c1); check("R4 disabled no capture", c1, c0);
    endtask

    task automatic t_recap;
        logic [15:0] v, c;
        logic [7:0] d;
        wr(4'd4, 8'h0C);
        pulse_ext(1);
        rd16(4'd1, v);
        set_pin(0, 1'b1);
        rd16(4'd5, c); check("R3 both-edge rise capture", c, v);
        pulse_ext(2);
        set_pin(0, 1'b0);
        rd16(4'd5, c); check("R5 recapture with flag set", c, 16'(v + 2));
        rd(4'd4, d);   check("R5 flag stays set", d, 8'h8C);
    endtask

    task automatic t_irq;
        check("R7 irq off without enable", irq[0], 0);
        wr(4'd4, 8'hCC);
        #1 check("R7 irq with flag and enable", irq[0], 1);
        wr(4'd4, 8'h4C);
        #1 check("R7 irq drops on clear", irq[0], 0);
    endtask

    task automatic t_coincide;
        logic [15:0] v, c;
        logic [7:0] d;
        set_pin(0, 1'b1);
        rd(4'd4, d); check("R6 flag set before race", d, 8'hCC);
        pulse_ext(1);
        rd16(4'd1, v);
        @(negedge clk);
        cap_pin[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 8'h4C;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        rd(4'd4, d);   check("R6 capture wins over clear", d, 8'hCC);
        rd16(4'd5, c); check("R6 race capture value", c, v);
        wr(4'd4, 8'h0C);
        rd(4'd4, d);   check("R6 plain clear after race", d, 8'h0C);
    endtask

    task automatic t_ch1;
        logic [15:0] v, c;
        logic [7:0] d;
        wr(4'd8, 8'h7F);
        rd(4'd8, d); check("R8 ch1 bit5 reserved", d, 8'h5F);
        wr(4'd4, 8'h7F);
        rd(4'd4, d); check("R8 ch0 all fields stored", d, 8'h7F);
        pulse_ext(2);
        rd16(4'd1, v);
        set_pin(1, 1'b1);
        rd16(4'd9, c); check("R2 R3 ch1 capture value", c, v);
        rd(4'd8, d);   check("R6 ch1 flag", d, 8'hDF);
        check("R7 ch1 irq", irq[1], 1);
        check("R7 ch0 irq idle", irq[0], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_prescale();
        t_ext();
        t_rise();
        t_fall();
        t_write1();
        t_off();
        t_recap();
        t_irq();
        t_coincide();
        t_ch1();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule